// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a fully associative cache of page translations. A lookup presents a virtual page number together with the identifier of the running address space. One clock later the block answers with hit or miss, the physical frame number and the permission bits, and it flags a protection fault when the access kind is not allowed by a matching entry. Because every entry carries its own address-space identifier, a context switch needs no flush: entries of other spaces simply fail to match. Entries marked global match under any identifier.

After a miss, the walker outside the block writes the translation through the refill port. The refill slot is picked in hardware. An existing entry for the same page and identifier is overwritten in place. Otherwise the lowest-numbered empty slot is used. When no slot is empty, a round-robin pointer picks a victim among the entries that are not wired. Wired entries are never evicted and survive both flush commands. When every slot is wired, the refill is dropped and an error pulse is raised. A control port can invalidate all entries of one identifier, or all entries at once.

Top module: `asid_tlb`

## Requirements
- R1: A lookup accepted on a clock edge produces `rs_valid` high in the following cycle only. With no lookup, `rs_valid` is low in the next cycle.
- R2: A lookup hits only when an entry is valid, its page number equals the request, and either its identifier equals the request identifier or the entry is global.
- R3: A lookup with no match reports `rs_miss` high and `rs_hit` low. After a refill of that page and identifier, the next lookup hits and returns the refilled frame number.
- R4: Permission bits are bit 0 read, bit 1 write and bit 2 execute. A write lookup needs bit 1. An execute lookup needs bit 2. Any other lookup needs bit 0. A hit whose access kind is not permitted reports `rs_fault` with `rs_hit` still high.
- R5: A refill of a new pair goes to the lowest-numbered empty slot when one exists, and does not move the round-robin pointer.
- R6: With no empty slot, the victim is the first unwired slot at or after the round-robin pointer. The pointer then moves to the slot after the victim. The pointer starts at slot 0.
- R7: A wired entry is never chosen as a refill victim, and no flush clears it.
- R8: When every slot is wired and the refill pair is new, the refill is dropped and `rf_err` is high for exactly the following cycle.
- R9: A refill whose page matches a valid entry overwrites that entry in place. A match requires the same identifier, or a global flag on either side. No two valid entries ever match the same lookup.
- R10: Control op 2 (flush by identifier) invalidates every valid entry that has the given identifier and is neither wired nor global.
- R11: Control op 1 (flush all) invalidates every entry that is neither wired nor global, in one cycle. Op 0 does nothing.
- R12: After reset every entry is invalid, and `rs_valid`, `rs_hit`, `rs_miss`, `rs_fault` and `rf_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_write | input | 1 | Lookup is a write access |
| lk_exec | input | 1 | Lookup is an instruction fetch |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | Translation found |
| rs_miss | output | 1 | Translation not found |
| rs_fault | output | 1 | Hit with a disallowed access kind |
| rs_pfn | output | PFN_W | Physical frame number on a hit |
| rs_perm | output | 3 | Permission bits of the hit entry |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | VPN_W | Refill page number |
| rf_asid | input | ASID_W | Refill identifier |
| rf_pfn | input | PFN_W | Refill frame number |
| rf_perm | input | 3 | Refill permission bits |
| rf_global | input | 1 | Refill entry matches every identifier |
| rf_wire | input | 1 | Refill entry is wired |
| rf_err | output | 1 | Refill dropped because every slot is wired |
| ctl_op | input | 2 | 0 none, 1 flush all, 2 flush by identifier |
| ctl_asid | input | ASID_W | Identifier for flush by identifier |

## Verification
The properties assume that `lk_valid`, `rf_valid` and `ctl_op` are known (not X) after reset. They also assume that refills arrive one per cycle with a stable payload while `rf_valid` is high. The uniqueness and single-match properties rely on refill being the only way entries are written. The bench drives every input on the falling edge and keeps all valids low during reset. It issues refills and flushes only through the defined encodings, so the properties see only legal command values.

// File: rtl/atlb_pkg.sv
package atlb_pkg;
   localparam int PERM_BITS = 3;
   localparam int PERM_RD   = 0;
   localparam int PERM_WR   = 1;
   localparam int PERM_EX   = 2;

   typedef enum logic [1:0] {
      OP_NONE       = 2'd0,
      OP_FLUSH_ALL  = 2'd1,
      OP_FLUSH_ASID = 2'd2
   } ctl_op_e;
endpackage

// File: rtl/atlb_match.sv
module atlb_match #(
   parameter int N      = 8,
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8
) (
   input  logic [N-1:0]             ent_valid,
   input  logic [N-1:0]             ent_glob,
   input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
   input  logic [N-1:0][ASID_W-1:0] ent_asid,
   input  logic [VPN_W-1:0]         q_vpn,
   input  logic [ASID_W-1:0]        q_asid,
   input  logic                     q_any,
   output logic [N-1:0]             hit
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      logic vpn_eq;
      logic asid_ok;
      assign vpn_eq  = (ent_vpn[i] == q_vpn);
      assign asid_ok = ent_glob[i] | q_any | (ent_asid[i] == q_asid);
      assign hit[i]  = ent_valid[i] & vpn_eq & asid_ok;
   end
endmodule

// File: rtl/atlb_victim.sv
module atlb_victim #(
   parameter int N = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     valid,
   input  logic [N-1:0]     wired,
   input  logic [IDX_W-1:0] rr_ptr,
   output logic             free_ok,
   output logic [IDX_W-1:0] free_idx,
   output logic             rr_ok,
   output logic [IDX_W-1:0] rr_idx
);
   always_comb begin
      free_ok  = 1'b0;
      free_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            free_ok  = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   always_comb begin
      int t;
      rr_ok  = 1'b0;
      rr_idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         t = int'(rr_ptr) + k;
         if (t >= N) t = t - N;
         if (!wired[t]) begin
            rr_ok  = 1'b1;
            rr_idx = IDX_W'(t);
         end
      end
   end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb #(
   parameter int N_ENTRIES = 8,
   parameter int VPN_W     = 20,
   parameter int PFN_W     = 20,
   parameter int ASID_W    = 8,
   localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
   localparam int PB       = atlb_pkg::PERM_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VPN_W-1:0]  lk_vpn,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_write,
   input  logic              lk_exec,
   output logic              rs_valid,
   output logic              rs_hit,
   output logic              rs_miss,
   output logic              rs_fault,
   output logic [PFN_W-1:0]  rs_pfn,
   output logic [PB-1:0]     rs_perm,
   input  logic              rf_valid,
   input  logic [VPN_W-1:0]  rf_vpn,
   input  logic [ASID_W-1:0] rf_asid,
   input  logic [PFN_W-1:0]  rf_pfn,
   input  logic [PB-1:0]     rf_perm,
   input  logic              rf_global,
   input  logic              rf_wire,
   output logic              rf_err,
   input  logic [1:0]        ctl_op,
   input  logic [ASID_W-1:0] ctl_asid
);
   import atlb_pkg::*;

   if (N_ENTRIES < 2) begin : g_bad_n
      $error("asid_tlb: N_ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PFN_W < 1 || ASID_W < 1) begin : g_bad_w
      $error("asid_tlb: field widths must be positive");
   end

   // Entry storage
   logic [N_ENTRIES-1:0]             e_valid, e_wired, e_glob;
   logic [N_ENTRIES-1:0][VPN_W-1:0]  e_vpn;
   logic [N_ENTRIES-1:0][ASID_W-1:0] e_asid;
   logic [N_ENTRIES-1:0][PFN_W-1:0]  e_pfn;
   logic [N_ENTRIES-1:0][PB-1:0]     e_perm;
   logic [IDX_W-1:0]                 rr_ptr;

   // Lookup compare
   logic [N_ENTRIES-1:0] lk_hit;
   atlb_match #(.N(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_match (
      .ent_valid(e_valid), .ent_glob(e_glob), .ent_vpn(e_vpn), .ent_asid(e_asid),
      .q_vpn(lk_vpn), .q_asid(lk_asid), .q_any(1'b0), .hit(lk_hit)
   );

   // Refill duplicate compare
   logic [N_ENTRIES-1:0] rf_hit;
   atlb_match #(.N(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_rf_match (
      .ent_valid(e_valid), .ent_glob(e_glob), .ent_vpn(e_vpn), .ent_asid(e_asid),
      .q_vpn(rf_vpn), .q_asid(rf_asid), .q_any(rf_global), .hit(rf_hit)
   );

   // Victim candidates
   logic             free_ok, rr_ok;
   logic [IDX_W-1:0] free_idx, rr_idx;
   atlb_victim #(.N(N_ENTRIES)) u_victim (
      .valid(e_valid), .wired(e_wired), .rr_ptr(rr_ptr),
      .free_ok(free_ok), .free_idx(free_idx), .rr_ok(rr_ok), .rr_idx(rr_idx)
   );

   // Lookup result selection
   logic [PFN_W-1:0] sel_pfn;
   logic [PB-1:0]    sel_perm;
   logic             any_hit, viol;
   always_comb begin
      sel_pfn  = '0;
      sel_perm = '0;
      for (int i = 0; i < N_ENTRIES; i++) begin
         if (lk_hit[i]) begin
            sel_pfn  = sel_pfn  | e_pfn[i];
            sel_perm = sel_perm | e_perm[i];
         end
      end
   end
   assign any_hit = |lk_hit;
   assign viol    = lk_write ? ~sel_perm[PERM_WR] :
                    lk_exec  ? ~sel_perm[PERM_EX] : ~sel_perm[PERM_RD];

   // Refill slot choice
   logic             dup, wr_en, rr_adv, drop;
   logic [IDX_W-1:0] dup_idx, wr_idx;
   always_comb begin
      dup_idx = '0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (rf_hit[i]) dup_idx = IDX_W'(i);
      end
   end
   assign dup = |rf_hit;

   always_comb begin
      wr_en  = 1'b0;
      rr_adv = 1'b0;
      drop   = 1'b0;
      wr_idx = '0;
      if (rf_valid) begin
         if (dup) begin
            wr_en  = 1'b1;
            wr_idx = dup_idx;
         end else if (free_ok) begin
            wr_en  = 1'b1;
            wr_idx = free_idx;
         end else if (rr_ok) begin
            wr_en  = 1'b1;
            rr_adv = 1'b1;
            wr_idx = rr_idx;
         end else begin
            drop   = 1'b1;
         end
      end
   end

   // Invalidation masks
   logic [N_ENTRIES-1:0] wr_oh, kill_dup, kill_fl;
   logic                 op_all, op_asid;
   assign op_all  = (ctl_op == OP_FLUSH_ALL);
   assign op_asid = (ctl_op == OP_FLUSH_ASID);
   assign wr_oh   = wr_en ? (N_ENTRIES'(1) << wr_idx) : '0;
   assign kill_dup = rf_valid ? (rf_hit & ~wr_oh) : '0;

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_flush
      assign kill_fl[i] = ~e_wired[i] & ~e_glob[i] &
                          (op_all | (op_asid & (e_asid[i] == ctl_asid)));
   end

   // Entry update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_valid <= '0;
         e_wired <= '0;
         e_glob  <= '0;
         e_vpn   <= '0;
         e_asid  <= '0;
         e_pfn   <= '0;
         e_perm  <= '0;
      end else begin
         for (int i = 0; i < N_ENTRIES; i++) begin
            if (kill_fl[i] | kill_dup[i]) begin
               e_valid[i] <= 1'b0;
               e_wired[i] <= 1'b0;
            end
            if (wr_oh[i]) begin
               e_valid[i] <= 1'b1;
               e_wired[i] <= rf_wire;
               e_glob[i]  <= rf_global;
               e_vpn[i]   <= rf_vpn;
               e_asid[i]  <= rf_asid;
               e_pfn[i]   <= rf_pfn;
               e_perm[i]  <= rf_perm;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_ptr <= '0;
         rf_err <= 1'b0;
      end else begin
         rf_err <= drop;
         if (rr_adv) rr_ptr <= (int'(rr_idx) == N_ENTRIES - 1) ? '0 : rr_idx + 1'b1;
      end
   end

   // Result register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_miss  <= 1'b0;
         rs_fault <= 1'b0;
         rs_pfn   <= '0;
         rs_perm  <= '0;
      end else begin
         rs_valid <= lk_valid;
         rs_hit   <= lk_valid & any_hit;
         rs_miss  <= lk_valid & ~any_hit;
         rs_fault <= lk_valid & any_hit & viol;
         rs_pfn   <= lk_valid ? sel_pfn  : '0;
         rs_perm  <= lk_valid ? sel_perm : '0;
      end
   end
endmodule

// File: rtl/atlb_chk.sv
module atlb_chk #(
   parameter int N      = 8,
   parameter int VPN_W  = 20,
   parameter int ASID_W = 8
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     lk_valid,
   input logic                     rs_valid,
   input logic                     rs_hit,
   input logic                     rs_miss,
   input logic                     rs_fault,
   input logic                     rf_valid,
   input logic                     rf_err,
   input logic [N-1:0]             lk_hit,
   input logic [N-1:0]             rf_hit,
   input logic [N-1:0]             e_valid,
   input logic [N-1:0]             e_wired,
   input logic [N-1:0][VPN_W-1:0]  e_vpn,
   input logic [N-1:0][ASID_W-1:0] e_asid
);
   logic dup_found;
   always_comb begin
      dup_found = 1'b0;
      for (int i = 0; i < N; i++) begin
         for (int j = i + 1; j < N; j++) begin
            if (e_valid[i] && e_valid[j] && e_vpn[i] == e_vpn[j] && e_asid[i] == e_asid[j])
               dup_found = 1'b1;
         end
      end
   end

   AST_LAT_ONE:      assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> rs_valid);            // R1
   AST_LAT_IDLE:     assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> !rs_valid);          // R1
   AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n) rs_valid |-> (rs_hit ^ rs_miss)); // R3
   AST_FAULT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n) rs_fault |-> rs_hit);              // R4
   AST_ONE_MATCH:    assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_hit));                 // R9
   AST_NO_DUP_PAIR:  assert property (@(posedge clk) disable iff (!rst_n) !dup_found);                       // R9
   AST_ERR_CAUSE:    assert property (@(posedge clk) disable iff (!rst_n) rf_err |-> $past(rf_valid));       // R8

   for (genvar i = 0; i < N; i++) begin : g_wired
      AST_WIRED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (e_valid[i] && e_wired[i] && !(rf_valid && rf_hit[i])) |=> e_valid[i]);                              // R7
   end
endmodule

bind asid_tlb atlb_chk #(.N(N_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .rs_valid(rs_valid), .rs_hit(rs_hit),
   .rs_miss(rs_miss), .rs_fault(rs_fault), .rf_valid(rf_valid), .rf_err(rf_err),
   .lk_hit(lk_hit), .rf_hit(rf_hit), .e_valid(e_valid), .e_wired(e_wired),
   .e_vpn(e_vpn), .e_asid(e_asid)
);

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;
   localparam int N = 8, VW = 20, PW = 20, AW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lk_valid = 0, lk_write = 0, lk_exec = 0;
   logic [VW-1:0] lk_vpn = '0;
   logic [AW-1:0] lk_asid = '0;
   logic rs_valid, rs_hit, rs_miss, rs_fault, rf_err;
   logic [PW-1:0] rs_pfn;
   logic [2:0] rs_perm;
   logic rf_valid = 0, rf_global = 0, rf_wire = 0;
   logic [VW-1:0] rf_vpn = '0;
   logic [AW-1:0] rf_asid = '0;
   logic [PW-1:0] rf_pfn = '0;
   logic [2:0] rf_perm = '0;
   logic [1:0] ctl_op = '0;
   logic [AW-1:0] ctl_asid = '0;

   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   asid_tlb #(.N_ENTRIES(N), .VPN_W(VW), .PFN_W(PW), .ASID_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
      .lk_write(lk_write), .lk_exec(lk_exec), .rs_valid(rs_valid), .rs_hit(rs_hit),
      .rs_miss(rs_miss), .rs_fault(rs_fault), .rs_pfn(rs_pfn), .rs_perm(rs_perm),
      .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_asid(rf_asid), .rf_pfn(rf_pfn),
      .rf_perm(rf_perm), .rf_global(rf_global), .rf_wire(rf_wire), .rf_err(rf_err),
      .ctl_op(ctl_op), .ctl_asid(ctl_asid)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Lookup: drive at falling edge, result sampled at the next falling edge
   task automatic look(input logic [VW-1:0] v, input logic [AW-1:0] a,
                       input bit wr, input bit ex);
      lk_valid = 1; lk_vpn = v; lk_asid = a; lk_write = wr; lk_exec = ex;
      @(negedge clk);
      lk_valid = 0; lk_write = 0; lk_exec = 0;
   endtask

   task automatic expect_hit(input logic [VW-1:0] v, input logic [AW-1:0] a,
                             input logic [PW-1:0] pfn, input string req);
      look(v, a, 0, 0);
      chk(rs_hit && !rs_miss, req, rs_hit, 1);
      chk(rs_pfn == pfn, req, rs_pfn, pfn);
   endtask

   task automatic expect_miss(input logic [VW-1:0] v, input logic [AW-1:0] a, input string req);
      look(v, a, 0, 0);
      chk(rs_miss && !rs_hit, req, rs_hit, 0);
   endtask

   task automatic refill(input logic [VW-1:0] v, input logic [AW-1:0] a, input logic [PW-1:0] p,
                         input logic [2:0] perm, input bit g, input bit w);
      rf_valid = 1; rf_vpn = v; rf_asid = a; rf_pfn = p; rf_perm = perm; rf_global = g; rf_wire = w;
      @(negedge clk);
      rf_valid = 0; rf_global = 0; rf_wire = 0;
   endtask

   task automatic control(input logic [1:0] op, input logic [AW-1:0] a);
      ctl_op = op; ctl_asid = a;
      @(negedge clk);
      ctl_op = 2'd0;
   endtask

   task automatic t_reset();
      do_reset();
      chk(!rs_valid && !rs_hit && !rs_miss && !rs_fault && !rf_err, "R12 outputs", rs_valid, 0);
      expect_miss(20'h00001, 8'd0, "R12 empty");
   endtask

   task automatic t_basic();
      do_reset();
      look(20'h00100, 8'd1, 0, 0);
      chk(rs_valid == 1, "R1 valid", rs_valid, 1);
      chk(rs_miss && !rs_hit, "R3 miss", rs_miss, 1);
      @(negedge clk);
      chk(rs_valid == 0, "R1 idle", rs_valid, 0);
      refill(20'h00100, 8'd1, 20'h0002A, 3'b111, 0, 0);
      expect_hit(20'h00100, 8'd1, 20'h0002A, "R3 refill");
   endtask

   task automatic t_asid();
      do_reset();
      refill(20'h00200, 8'd1, 20'h00011, 3'b111, 0, 0);
      expect_miss(20'h00200, 8'd2, "R2 other asid");
      expect_hit(20'h00200, 8'd1, 20'h00011, "R2 same asid");
      refill(20'h00300, 8'd5, 20'h00033, 3'b111, 1, 0);
      expect_hit(20'h00300, 8'd9, 20'h00033, "R2 global");
      expect_miss(20'h00301, 8'd5, "R2 other vpn");
   endtask

   task automatic t_perm();
      do_reset();
      refill(20'h00400, 8'd1, 20'h00044, 3'b001, 0, 0);
      look(20'h00400, 8'd1, 0, 0);
      chk(rs_hit && !rs_fault, "R4 read ok", rs_fault, 0);
      chk(rs_perm == 3'b001, "R4 perm out", rs_perm, 1);
      look(20'h00400, 8'd1, 1, 0);
      chk(rs_hit && rs_fault, "R4 write fault", rs_fault, 1);
      look(20'h00400, 8'd1, 0, 1);
      chk(rs_hit && rs_fault, "R4 exec fault", rs_fault, 1);
      refill(20'h00401, 8'd1, 20'h00045, 3'b010, 0, 0);
      look(20'h00401, 8'd1, 1, 0);
      chk(rs_hit && !rs_fault, "R4 write ok", rs_fault, 0);
      look(20'h00401, 8'd1, 0, 0);
      chk(rs_hit && rs_fault, "R4 read fault", rs_fault, 1);
   endtask

   task automatic t_overwrite();
      do_reset();
      refill(20'h00500, 8'd1, 20'h00001, 3'b111, 0, 0);
      refill(20'h00500, 8'd1, 20'h00002, 3'b111, 0, 0);
      expect_hit(20'h00500, 8'd1, 20'h00002, "R9 in place");
      refill(20'h00510, 8'd3, 20'h00007, 3'b111, 0, 0);
      refill(20'h00510, 8'd4, 20'h00008, 3'b111, 1, 0);
      expect_hit(20'h00510, 8'd3, 20'h00008, "R9 global replaces");
   endtask

   task automatic t_free_rr();
      do_reset();
      for (int i = 0; i < N; i++)
         refill(20'h00010 + VW'(i), (i == 3) ? 8'd7 : 8'd1, 20'h00100 + PW'(i), 3'b111, 0, 0);
      control(2'd2, 8'd7);
      refill(20'h00020, 8'd1, 20'h00220, 3'b111, 0, 0);
      refill(20'h00021, 8'd1, 20'h00221, 3'b111, 0, 0);
      expect_hit(20'h00020, 8'd1, 20'h00220, "R5 free slot used");
      expect_hit(20'h00011, 8'd1, 20'h00101, "R5 slot1 kept");
      expect_miss(20'h00010, 8'd1, "R6 slot0 evicted");
      refill(20'h00022, 8'd1, 20'h00222, 3'b111, 0, 0);
      expect_miss(20'h00011, 8'd1, "R6 slot1 evicted");
      expect_hit(20'h00012, 8'd1, 20'h00102, "R6 slot2 kept");
   endtask

   task automatic t_wired();
      do_reset();
      for (int i = 0; i < N; i++)
         refill(20'h00030 + VW'(i), 8'd1, 20'h00300 + PW'(i), 3'b111, 0, i < 2);
      refill(20'h00038, 8'd1, 20'h00338, 3'b111, 0, 0);
      expect_miss(20'h00032, 8'd1, "R7 first unwired evicted");
      expect_hit(20'h00030, 8'd1, 20'h00300, "R7 wired kept");
      expect_hit(20'h00031, 8'd1, 20'h00301, "R7 wired kept");
      control(2'd1, 8'd0);
      expect_miss(20'h00038, 8'd1, "R11 flush all");
      expect_hit(20'h00030, 8'd1, 20'h00300, "R7 survives flush");
   endtask

   task automatic t_allwired();
      do_reset();
      for (int i = 0; i < N; i++)
         refill(20'h00040 + VW'(i), 8'd1, 20'h00400 + PW'(i), 3'b111, 0, 1);
      chk(rf_err == 0, "R8 no err yet", rf_err, 0);
      refill(20'h00050, 8'd1, 20'h00500, 3'b111, 0, 0);
      chk(rf_err == 1, "R8 err pulse", rf_err, 1);
      @(negedge clk);
      chk(rf_err == 0, "R8 err one cycle", rf_err, 0);
      expect_miss(20'h00050, 8'd1, "R8 dropped");
      expect_hit(20'h00047, 8'd1, 20'h00407, "R8 table intact");
   endtask

   task automatic t_flush_asid();
      do_reset();
      refill(20'h00060, 8'd1, 20'h00600, 3'b111, 0, 0);
      refill(20'h00061, 8'd2, 20'h00601, 3'b111, 0, 0);
      refill(20'h00062, 8'd1, 20'h00602, 3'b111, 1, 0);
      refill(20'h00063, 8'd1, 20'h00603, 3'b111, 0, 1);
      control(2'd0, 8'd1);
      expect_hit(20'h00060, 8'd1, 20'h00600, "R11 op0 no effect");
      control(2'd2, 8'd1);
      expect_miss(20'h00060, 8'd1, "R10 asid flushed");
      expect_hit(20'h00061, 8'd2, 20'h00601, "R10 other asid kept");
      expect_hit(20'h00062, 8'd1, 20'h00602, "R10 global kept");
      expect_hit(20'h00063, 8'd1, 20'h00603, "R10 wired kept");
      control(2'd1, 8'd0);
      expect_miss(20'h00061, 8'd2, "R11 flush all");
      expect_hit(20'h00062, 8'd3, 20'h00602, "R11 global kept");
   endtask

   initial begin
      t_reset();
      t_basic();
      t_asid();
      t_perm();
      t_overwrite();
      t_free_rr();
      t_wired();
      t_allwired();
      t_flush_asid();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule